// File: doc/BRIEF.md
# Falling-Edge Input Event Latches

This block watches two asynchronous input lines, an upper line and a lower line, for low-going pulses that stay low long enough to count. Each line feeds its own sticky latch. Once a line's latch is set it stays set until software reads it. Sampling is paced by an instruction-cycle enable, so the minimum pulse width is counted in instruction cycles rather than in raw clocks. Both lines, and a general-purpose input pin, pass through a two-flop synchroniser before any logic looks at them.

A read strobe presents a packed 4-bit nibble. The nibble holds the upper latch, an optional general-purpose pin level, the current accumulator bit 0 and the lower latch. On the clock edge that ends the strobe, both latches are cleared, so they can catch later pulses. If a qualifying event arrives on the same edge as the read, the event takes priority and the latch remains set. The surrounding core stores the nibble in its accumulator.

Top module: `fall_event_capture`

## Requirements
- R1: A line's latch sets when, at cycle-enable points, its synchronised level is sampled high and then sampled low at QUAL_CYCLES (default 2) consecutive cycle-enable points. It sets on the edge of the last of those low samples.
- R2: A line that is sampled low fewer than QUAL_CYCLES times before it is sampled high again does not set its latch. Its low count restarts from zero.
- R3: nibble_o bit 3 shows the upper-line latch and nibble_o bit 0 shows the lower-line latch. Without a set or a read, the latches hold their value.
- R4: A clock edge with rd_en high clears every latch that is not being set on that same edge.
- R5: nibble_o bit 2 equals the synchronised gp_pin when gp_en is 1, and reads constant 1 when gp_en is 0.
- R6: nibble_o bit 1 equals acc_b0 combinationally.
- R7: Reset (rst_n low, asynchronous) clears both latches, the synchroniser stages and the qualification state.
- R8: If a latch qualifies on the same edge as a read, it is set after that edge.
- R9: Input pins pass through SYNC_STAGES (default 2) flops. A pin change reaches the qualifier, and bit 2 of nibble_o, after that many clock edges.
- R10: Clock edges with cyc_en low neither sample the lines nor advance the low count.
- R11: A line held low sets its latch at most once per falling edge. After a read, the latch stays clear until the line has been high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable; sampling point for line levels |
| rd_en | input | 1 | Read strobe; clears the latches at the clock edge |
| upper_line_i | input | 1 | Asynchronous upper event line (reported in bit 3) |
| lower_line_i | input | 1 | Asynchronous lower event line (reported in bit 0) |
| gp_pin | input | 1 | Asynchronous general-purpose input (bit 2 when enabled) |
| gp_en | input | 1 | Selects gp_pin for bit 2; 0 forces bit 2 to 1 |
| acc_b0 | input | 1 | Current accumulator bit 0 (bit 1) |
| nibble_o | output | 4 | Packed read value |

## Verification
The hardest case to reach from the ports is a read strobe that lands on exactly the edge where a line completes its qualification. The stimulus has to account for the full synchroniser latency and for the first low sample before it raises rd_en. The bench does this with cyc_en held high throughout. It drops the lower line, waits three edges so the level can cross both synchroniser stages and be sampled once, and then raises rd_en for the fourth edge. A second hard case is a line held low while cyc_en is idle; the bench shows that no count accumulates until enables resume. A behavioural model with queued pin history checks every cycle against the design.

// File: rtl/evtlat_pkg.sv
package evtlat_pkg;

  // Bit positions of the packed read value
  localparam int POS_UPPER = 3;
  localparam int POS_GP    = 2;
  localparam int POS_ACC   = 1;
  localparam int POS_LOWER = 0;

  // Assemble the nibble from its four sources
  function automatic logic [3:0] pack_nibble(input logic upper, input logic gp_sel,
                                             input logic gp_lvl, input logic acc,
                                             input logic lower);
    logic [3:0] n;
    n            = '0;
    n[POS_UPPER] = upper;
    n[POS_GP]    = gp_sel ? gp_lvl : 1'b1;
    n[POS_ACC]   = acc;
    n[POS_LOWER] = lower;
    return n;
  endfunction

  // Next low-run count: a fresh fall starts at one, a continuing low adds one
  function automatic int unsigned next_run(input logic fresh, input int unsigned cur);
    return fresh ? 1 : cur + 1;
  endfunction

endpackage

// File: rtl/evtlat_sync.sv
module evtlat_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/evtlat_qual.sv
module evtlat_qual
  import evtlat_pkg::*;
#(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic lvl_i,
  output logic fire_o
);

  localparam int CW = $clog2(QUAL + 1);

  logic          prev_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          fall_w;
  logic          cont_w;
  logic [CW-1:0] cnt_next_w;

  // Event wires brought out for the checks below
  assign fall_w     = cyc_en && prev_q && !lvl_i;
  assign cont_w     = cyc_en && armed_q && !lvl_i;
  assign cnt_next_w = CW'(next_run(fall_w, int'(cnt_q)));
  assign fire_o     = (fall_w || cont_w) && (int'(cnt_next_w) == QUAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cyc_en) begin
      prev_q <= lvl_i;
      if (lvl_i || fire_o) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (fall_w || cont_w) begin
        armed_q <= 1'b1;
        cnt_q   <= cnt_next_w;
      end
    end
  end

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(cnt_q) && $stable(prev_q));

  a_r1_fire_on_low_sample: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (cyc_en && !lvl_i));

  a_r11_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  a_r2_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && lvl_i) |=> (cnt_q == '0) && !armed_q);

endmodule

// File: rtl/evtlat_sticky.sv
module evtlat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  a_r3_holds_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/fall_event_capture.sv
module fall_event_capture
  import evtlat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       rd_en,
  input  logic       upper_line_i,
  input  logic       lower_line_i,
  input  logic       gp_pin,
  input  logic       gp_en,
  input  logic       acc_b0,
  output logic [3:0] nibble_o
);

  localparam int NLINE = 2;          // index 0: lower line, index 1: upper line
  localparam int SW    = NLINE + 1;  // lines plus the general-purpose pin

  logic [SW-1:0]    raw_w;
  logic [SW-1:0]    syn_w;
  logic [NLINE-1:0] fire_w;
  logic [NLINE-1:0] latch_w;

  assign raw_w = {gp_pin, upper_line_i, lower_line_i};

  evtlat_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_w),
    .q_o  (syn_w)
  );

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    evtlat_qual #(.QUAL(QUAL_CYCLES)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .cyc_en(cyc_en),
      .lvl_i (syn_w[g]),
      .fire_o(fire_w[g])
    );

    evtlat_sticky u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(fire_w[g]),
      .clr_i(rd_en),
      .q_o  (latch_w[g])
    );
  end

  assign nibble_o = pack_nibble(latch_w[1], gp_en, syn_w[NLINE], acc_b0, latch_w[0]);

  a_r5_bit2_default_one: assert property (@(posedge clk) disable iff (!rst_n)
    !gp_en |-> nibble_o[2]);

  a_r7_latches_follow_fires: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nibble_o[0]) |-> $past(fire_w[0]));

endmodule

// File: tb/fall_event_capture_test.sv
module fall_event_capture_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       upper_line_i = 1'b1;
  logic       lower_line_i = 1'b1;
  logic       gp_pin = 1'b0;
  logic       gp_en = 1'b0;
  logic       acc_b0 = 1'b0;
  logic [3:0] nibble_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #(CLK_P/2) clk = ~clk;

  fall_event_capture uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_en      (cyc_en),
    .rd_en       (rd_en),
    .upper_line_i(upper_line_i),
    .lower_line_i(lower_line_i),
    .gp_pin      (gp_pin),
    .gp_en       (gp_en),
    .acc_b0      (acc_b0),
    .nibble_o    (nibble_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history queue, run counters, flag per line
  logic [2:0] hist[$];     // {gp, upper, lower} per edge
  int         run[2];
  bit         prv[2];
  bit         mlat[2];

  always @(posedge clk) begin
    logic [2:0] s;
    bit         f;
    if (!rst_n) begin
      hist = {3'b000, 3'b000};
      run  = '{0, 0};
      prv  = '{0, 0};
      mlat = '{0, 0};
    end else begin
      s = hist.pop_front();
      hist.push_back({gp_pin, upper_line_i, lower_line_i});
      for (int k = 0; k < 2; k++) begin
        f = 0;
        if (cyc_en) begin
          if (!s[k] && prv[k])           run[k] = 1;
          else if (!s[k] && run[k] > 0)  run[k] = run[k] + 1;
          else                           run[k] = 0;
          if (run[k] >= 2) begin f = 1; run[k] = 0; end
          prv[k] = s[k];
        end
        if (f)          mlat[k] = 1;
        else if (rd_en) mlat[k] = 0;
      end
    end
    #(CLK_P/4);
    if (hist.size() == 2) begin
      check(nibble_o[3] == mlat[1], "R3 upper bit", nibble_o[3], mlat[1]);
      check(nibble_o[0] == mlat[0], "R3 lower bit", nibble_o[0], mlat[0]);
      check(nibble_o[2] == (gp_en ? hist[0][2] : 1'b1), "R5 bit2", nibble_o[2],
            gp_en ? hist[0][2] : 1);
      check(nibble_o[1] == acc_b0, "R6 bit1", nibble_o[1], acc_b0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    tick(3);
    // R7: reset state
    check(nibble_o[3] == 0, "R7 upper after reset", nibble_o[3], 0);
    check(nibble_o[0] == 0, "R7 lower after reset", nibble_o[0], 0);
    rst_n  = 1'b1;
    cyc_en = 1'b1;
    tick(4);

    // R6: accumulator bit passes through
    acc_b0 = 1'b1; #1;
    check(nibble_o[1] == 1, "R6 acc high", nibble_o[1], 1);
    acc_b0 = 1'b0; #1;
    check(nibble_o[1] == 0, "R6 acc low", nibble_o[1], 0);

    // R1: long low pulse on the upper line sets bit 3 only
    upper_line_i = 1'b0; tick(6); upper_line_i = 1'b1; tick(3);
    check(nibble_o[3] == 1, "R1 upper set", nibble_o[3], 1);
    check(nibble_o[0] == 0, "R3 lower untouched", nibble_o[0], 0);

    // R4: read clears
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
    check(nibble_o[3] == 0, "R4 cleared by read", nibble_o[3], 0);

    // R2: single-sample low pulses do not qualify
    lower_line_i = 1'b0; tick(1); lower_line_i = 1'b1; tick(1);
    lower_line_i = 1'b0; tick(1); lower_line_i = 1'b1; tick(4);
    check(nibble_o[0] == 0, "R2 short pulses ignored", nibble_o[0], 0);

    // R3: lower-only event lands in bit 0
    lower_line_i = 1'b0; tick(5); lower_line_i = 1'b1; tick(3);
    check(nibble_o[0] == 1, "R3 lower set", nibble_o[0], 1);
    check(nibble_o[3] == 0, "R3 upper clear", nibble_o[3], 0);
    rd_en = 1'b1; tick(1); rd_en = 1'b0;

    // R10: no sampling while cycle enable idle
    cyc_en = 1'b0; lower_line_i = 1'b0; tick(10);
    check(nibble_o[0] == 0, "R10 idle enable", nibble_o[0], 0);
    cyc_en = 1'b1; tick(1);
    check(nibble_o[0] == 0, "R10 first enabled sample", nibble_o[0], 0);
    tick(1);
    check(nibble_o[0] == 1, "R1 second enabled sample", nibble_o[0], 1);

    // R11: held low, read, no re-trigger
    rd_en = 1'b1; tick(1); rd_en = 1'b0; tick(6);
    check(nibble_o[0] == 0, "R11 no re-fire while low", nibble_o[0], 0);
    lower_line_i = 1'b1; tick(4);

    // R8: qualification on the read edge survives
    lower_line_i = 1'b0; tick(3);
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
    check(nibble_o[0] == 1, "R8 set beats read", nibble_o[0], 1);
    lower_line_i = 1'b1;
    rd_en = 1'b1; tick(1); rd_en = 1'b0; tick(2);

    // R9 / R5: gp pin latency and option select
    gp_en = 1'b1; gp_pin = 1'b0; tick(4);
    gp_pin = 1'b1; tick(1);
    check(nibble_o[2] == 0, "R9 gp after one edge", nibble_o[2], 0);
    tick(1);
    check(nibble_o[2] == 1, "R9 gp after two edges", nibble_o[2], 1);
    gp_pin = 1'b0; tick(3);
    check(nibble_o[2] == 0, "R5 gp low selected", nibble_o[2], 0);
    gp_en = 1'b0; #1;
    check(nibble_o[2] == 1, "R5 forced one", nibble_o[2], 1);

    // R7: reset mid-run clears a set latch
    upper_line_i = 1'b0; tick(6); upper_line_i = 1'b1; tick(2);
    check(nibble_o[3] == 1, "R1 upper set again", nibble_o[3], 1);
    rst_n = 1'b0; #1;
    check(nibble_o[3] == 0, "R7 async reset", nibble_o[3], 0);
    tick(2); rst_n = 1'b1; tick(4);

    done = 1;
    finish_run();
  end

endmodule